// File: doc/BRIEF.md
# Programmable-Modulus MASH Fractional-N Divide Sequencer

This block produces the instantaneous divide value for the feedback divider of a fractional-N PLL. Each time the divider completes a cycle (represented here by one rising edge of `clk` with `enable` high), the block emits one divide value on `div_out`, marked by `div_valid`. In integer mode that value is the configured integer divide. In fractional mode it is the integer divide plus a small signed correction. The correction comes from a cascade of up to three modulo accumulators. Their wrap point is a programmable 24-bit modulus rather than a power of two, so any ratio `int + num/den` is reachable with zero long-run frequency error.

The cascade order (first, second or third) is chosen at run time. The carries are recombined with noise-cancelling differences: `c1 + (c2 - c2') + (c3 - 2*c3' + c3'')`, where a prime means the value from the previous step. Configuration is captured only on a synchronous clear, which also empties every accumulator and every carry history register. Inputs can therefore change freely between clears without disturbing a running sequence.

A small controller holds the block in one of three named states:

- `S_WAIT`: after reset, waiting for the first configuration.
- `S_INT`: integer sequencing.
- `S_FRAC`: modulated sequencing.

The named transitions are:

- `T_LOAD_INT`: `sync_clr` while the captured setting is not a usable fraction. It is taken from any state and leads to `S_INT`.
- `T_LOAD_FRAC`: `sync_clr` while the captured setting is a usable fraction. It is taken from any state and leads to `S_FRAC`.
- `T_HOLD`: no `sync_clr`. The state is kept.

Top module: `mash_fracn_mod`

## Requirements
- R1: After `rst_n` is released, `div_valid` is 0 and `div_out` is 0, and both stay so, whatever `enable` does, until the first `sync_clr`.
- R2: A cycle with `sync_clr` high captures `int_div`, `numer`, `denom`, `frac_en` and `order`, clears all accumulators and carry history, and gives `div_valid` = 0 in the following cycle. Changes to those inputs without `sync_clr` have no effect on the output sequence.
- R3: In `S_INT` or `S_FRAC`, each edge with `enable` high and `sync_clr` low advances the sequence by exactly one step and presents its value with `div_valid` = 1 after that edge. An edge with `enable` low gives `div_valid` = 0 and leaves the sequence where it was.
- R4: In integer mode (`frac_en` = 0 captured), every valid `div_out` equals the captured `int_div`.
- R5: If `frac_en` = 1 is captured with `numer` = 0, with `denom` = 0, or with `numer` >= `denom`, the block behaves as in integer mode and every valid output equals `int_div`.
- R6: Each accumulator stage forms sum = state + input. When sum >= `denom` it stores sum - `denom` and carries 1; otherwise it stores sum and carries 0. Stage 1 adds `numer`, and stage k+1 adds the new stored value of stage k of the same step.
- R7: With order code 1, `div_out` = `int_div` + c1. Over the first `denom` steps after a clear, exactly `numer` outputs equal `int_div`+1 and the rest equal `int_div`.
- R8: With order code 2, `div_out` = `int_div` + c1 + c2 - c2', which stays in `int_div`-1 .. `int_div`+2.
- R9: With order code 3, `div_out` = `int_div` + c1 + c2 - c2' + c3 - 2*c3' + c3'', which stays in `int_div`-3 .. `int_div`+4. Order code 0 behaves as order code 1.
- R10: For every order, after n steps from a clear, the sum of all valid outputs minus n*(`int_div` + `numer`/`denom`) lies within ±3, so the average ratio carries no error.
- R11: In fractional mode every accumulator value stays below the captured `denom`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider-rate clock, one step per rising edge when enabled |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Step request for this divider cycle |
| sync_clr | input | 1 | Capture configuration and clear accumulators; wins over `enable` |
| frac_en | input | 1 | 1 selects fractional mode, 0 selects integer mode |
| order | input | 2 | Cascade order code: 1, 2 or 3 (0 acts as 1) |
| int_div | input | DIV_W (8) | Integer part of the divide ratio; must be at least 3 in fractional mode |
| numer | input | FRAC_W (24) | Fraction numerator |
| denom | input | FRAC_W (24) | Fraction denominator and accumulator modulus |
| div_out | output | DIV_W+1 (9) | Divide value for this divider cycle |
| div_valid | output | 1 | `div_out` holds a new step value |

## Verification
The bench builds the block with its defaults: an 8-bit integer part and 24-bit numerator and denominator. This lets it run small prime moduli such as 37 and 1021 for full modulus-length windows. The window counts and long-run sums of R7 and R10 close within a few thousand cycles. The full 24-bit modulus, with a numerator one short of it, exercises the widest accumulator sums and the carry at the top of the range. Integer values of 20 and up keep the negative third-order corrections clear of the output's lower limit.

// File: rtl/mash_pkg.sv
package mash_pkg;

    typedef enum logic [1:0] {
        S_WAIT = 2'd0,
        S_INT  = 2'd1,
        S_FRAC = 2'd2
    } mash_state_e;

    localparam int CORR_W = 4;

endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] addend,
    input  logic [FRAC_W-1:0] modulus,
    output logic [FRAC_W-1:0] acc_q,
    output logic [FRAC_W-1:0] acc_next,
    output logic              carry
);

    localparam int SUM_W = FRAC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        sum      = {1'b0, acc_q} + {1'b0, addend};
        carry    = (sum >= {1'b0, modulus});
        wrapped  = sum - {1'b0, modulus};
        acc_next = carry ? wrapped[FRAC_W-1:0] : sum[FRAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/mash_noise_shaper.sv
module mash_noise_shaper
    import mash_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     step,
    input  logic [1:0]               order_sel,
    input  logic [STAGES-1:0]        carries,
    output logic signed [CORR_W-1:0] corr
);

    logic c2_d1;
    logic c3_d1;
    logic c3_d2;

    logic signed [CORR_W-1:0] t1;
    logic signed [CORR_W-1:0] t2;
    logic signed [CORR_W-1:0] t3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (clr) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (step) begin
            c2_d1 <= carries[1];
            c3_d1 <= carries[2];
            c3_d2 <= c3_d1;
        end
    end

    always_comb begin
        t1 = $signed({{(CORR_W-1){1'b0}}, carries[0]});
        t2 = $signed({{(CORR_W-1){1'b0}}, carries[1]})
           - $signed({{(CORR_W-1){1'b0}}, c2_d1});
        t3 = $signed({{(CORR_W-1){1'b0}}, carries[2]})
           - $signed({{(CORR_W-2){1'b0}}, c3_d1, 1'b0})
           + $signed({{(CORR_W-1){1'b0}}, c3_d2});
        unique case (order_sel)
            2'd2:    corr = t1 + t2;
            2'd3:    corr = t1 + t2 + t3;
            default: corr = t1;
        endcase
    end

endmodule

// File: rtl/mash_ctrl_fsm.sv
module mash_ctrl_fsm
    import mash_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              enable,
    input  logic              frac_en,
    input  logic [1:0]        order,
    input  logic [DIV_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] numer,
    input  logic [FRAC_W-1:0] denom,
    output mash_state_e       state,
    output logic [DIV_W-1:0]  int_cfg,
    output logic [FRAC_W-1:0] num_cfg,
    output logic [FRAC_W-1:0] den_cfg,
    output logic [1:0]        order_cfg,
    output logic              clr,
    output logic              step_int,
    output logic              step_frac
);

    mash_state_e state_nx;
    logic        frac_usable;

    assign frac_usable = frac_en && (numer != '0) && (denom != '0) && (numer < denom);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_WAIT, S_INT, S_FRAC: begin
                if (sync_clr) begin
                    state_nx = frac_usable ? S_FRAC : S_INT;
                end
            end
            default: state_nx = S_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_cfg   <= '0;
            num_cfg   <= '0;
            den_cfg   <= '0;
            order_cfg <= 2'd1;
        end else if (sync_clr) begin
            int_cfg   <= int_div;
            num_cfg   <= numer;
            den_cfg   <= denom;
            order_cfg <= (order == 2'd0) ? 2'd1 : order;
        end
    end

    always_comb begin
        clr       = sync_clr;
        step_int  = 1'b0;
        step_frac = 1'b0;
        unique case (state)
            S_WAIT: begin
                step_int  = 1'b0;
                step_frac = 1'b0;
            end
            S_INT: begin
                step_int  = enable && !sync_clr;
            end
            S_FRAC: begin
                step_frac = enable && !sync_clr;
            end
            default: begin
                step_int  = 1'b0;
                step_frac = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mash_fracn_mod.sv
module mash_fracn_mod
    import mash_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sync_clr,
    input  logic              frac_en,
    input  logic [1:0]        order,
    input  logic [DIV_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] numer,
    input  logic [FRAC_W-1:0] denom,
    output logic [DIV_W:0]    div_out,
    output logic              div_valid
);

    localparam int STAGES = 3;
    localparam int OUT_W  = DIV_W + 1;

    mash_state_e              state;
    logic [DIV_W-1:0]         int_cfg;
    logic [FRAC_W-1:0]        num_cfg;
    logic [FRAC_W-1:0]        den_cfg;
    logic [1:0]               order_cfg;
    logic                     clr;
    logic                     step_int;
    logic                     step_frac;
    logic [FRAC_W-1:0]        stage_in  [STAGES];
    logic [FRAC_W-1:0]        stage_acc [STAGES];
    logic [FRAC_W-1:0]        stage_nxt [STAGES];
    logic [STAGES-1:0]        carries;
    logic signed [CORR_W-1:0] corr;
    logic [OUT_W-1:0]         corr_ext;

    mash_ctrl_fsm #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .enable   (enable),
        .frac_en  (frac_en),
        .order    (order),
        .int_div  (int_div),
        .numer    (numer),
        .denom    (denom),
        .state    (state),
        .int_cfg  (int_cfg),
        .num_cfg  (num_cfg),
        .den_cfg  (den_cfg),
        .order_cfg(order_cfg),
        .clr      (clr),
        .step_int (step_int),
        .step_frac(step_frac)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign stage_in[k] = num_cfg;
        end else begin : g_chain
            assign stage_in[k] = stage_nxt[k-1];
        end

        mash_acc_stage #(
            .FRAC_W(FRAC_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .step    (step_frac),
            .addend  (stage_in[k]),
            .modulus (den_cfg),
            .acc_q   (stage_acc[k]),
            .acc_next(stage_nxt[k]),
            .carry   (carries[k])
        );
    end

    mash_noise_shaper #(
        .STAGES(STAGES)
    ) u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (step_frac),
        .order_sel(order_cfg),
        .carries  (carries),
        .corr     (corr)
    );

    assign corr_ext = {{(OUT_W-CORR_W){corr[CORR_W-1]}}, corr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_out   <= '0;
            div_valid <= 1'b0;
        end else if (clr) begin
            div_valid <= 1'b0;
        end else if (step_frac) begin
            div_out   <= {1'b0, int_cfg} + corr_ext;
            div_valid <= 1'b1;
        end else if (step_int) begin
            div_out   <= {1'b0, int_cfg};
            div_valid <= 1'b1;
        end else begin
            div_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mash_fracn_chk.sv
module mash_fracn_chk
    import mash_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              sync_clr,
    input logic [DIV_W:0]    div_out,
    input logic              div_valid,
    input mash_state_e       state,
    input logic [DIV_W-1:0]  int_cfg,
    input logic [FRAC_W-1:0] den_cfg,
    input logic [1:0]        order_cfg,
    input logic [FRAC_W-1:0] acc0,
    input logic [FRAC_W-1:0] acc1,
    input logic [FRAC_W-1:0] acc2
);

    logic signed [DIV_W:0] delta;
    logic                  in_frac;

    assign delta   = $signed(div_out - {1'b0, int_cfg});
    assign in_frac = (state == S_FRAC);

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> !div_valid) else $error("wait"); // R1

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_clr) |-> !div_valid) else $error("clr"); // R2

    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |-> $past(enable)) else $error("en"); // R3

    AST_INT_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && !in_frac) |-> (div_out == {1'b0, int_cfg})) else $error("int"); // R4

    AST_RANGE_ORD1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && in_frac && order_cfg == 2'd1) |-> (delta >= 0 && delta <= 1)) else $error("o1"); // R7

    AST_RANGE_ORD2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && in_frac && order_cfg == 2'd2) |-> (delta >= -1 && delta <= 2)) else $error("o2"); // R8

    AST_RANGE_ORD3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && in_frac && order_cfg == 2'd3) |-> (delta >= -3 && delta <= 4)) else $error("o3"); // R9

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_frac |-> (acc0 < den_cfg && acc1 < den_cfg && acc2 < den_cfg)) else $error("acc"); // R11

endmodule

bind mash_fracn_mod mash_fracn_chk #(
    .DIV_W (DIV_W),
    .FRAC_W(FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .sync_clr (sync_clr),
    .div_out  (div_out),
    .div_valid(div_valid),
    .state    (state),
    .int_cfg  (int_cfg),
    .den_cfg  (den_cfg),
    .order_cfg(order_cfg),
    .acc0     (stage_acc[0]),
    .acc1     (stage_acc[1]),
    .acc2     (stage_acc[2])
);

// File: tb/sim_mash_fracn_mod.sv
`timescale 1ns/1ps
module sim_mash_fracn_mod;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        sync_clr = 1'b0;
    logic        frac_en = 1'b0;
    logic [1:0]  order = 2'd1;
    logic [7:0]  int_div = '0;
    logic [23:0] numer = '0;
    logic [23:0] denom = '0;
    logic [8:0]  div_out;
    logic        div_valid;

    int n_checks = 0;
    int n_fails  = 0;

    // behavioural reference state
    longint m_int, m_num, m_den;
    int     m_ord;
    bit     m_frac;
    longint a1, a2, a3;
    int     h2, h3a, h3b;
    longint m_steps, m_sum;
    int     m_ones;

    always #10 clk = ~clk;

    mash_fracn_mod u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .sync_clr (sync_clr),
        .frac_en  (frac_en),
        .order    (order),
        .int_div  (int_div),
        .numer    (numer),
        .denom    (denom),
        .div_out  (div_out),
        .div_valid(div_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int model_step();
        int c1, c2, c3, y;
        if (!m_frac) return int'(m_int);
        a1 = a1 + m_num; c1 = (a1 >= m_den) ? 1 : 0; if (c1 == 1) a1 = a1 - m_den;
        a2 = a2 + a1;    c2 = (a2 >= m_den) ? 1 : 0; if (c2 == 1) a2 = a2 - m_den;
        a3 = a3 + a2;    c3 = (a3 >= m_den) ? 1 : 0; if (c3 == 1) a3 = a3 - m_den;
        y = c1;
        if (m_ord >= 2) y = y + c2 - h2;
        if (m_ord == 3) y = y + c3 - 2 * h3a + h3b;
        h2 = c2; h3b = h3a; h3a = c3;
        return int'(m_int) + y;
    endfunction

    task automatic load(input bit fe, input logic [1:0] od, input int iv, input longint nu, input longint de);
        frac_en  = fe;
        order    = od;
        int_div  = 8'(iv);
        numer    = 24'(nu);
        denom    = 24'(de);
        sync_clr = 1'b1;
        enable   = 1'b1;
        tick();
        sync_clr = 1'b0;
        m_int = iv; m_num = nu; m_den = de;
        m_ord = (od == 2'd0) ? 1 : int'(od);
        m_frac = fe && nu != 0 && de != 0 && nu < de;
        a1 = 0; a2 = 0; a3 = 0; h2 = 0; h3a = 0; h3b = 0;
        m_steps = 0; m_sum = 0; m_ones = 0;
        check(div_valid == 1'b0, "R2 valid low after clear", div_valid, 0);
    endtask

    // run n cycles with given enable pattern (0: always on, k>0: off every k-th)
    task automatic run(input int n, input int gap, input string req);
        int exp;
        for (int i = 0; i < n; i++) begin
            enable = (gap > 0 && (i % gap) == gap - 1) ? 1'b0 : 1'b1;
            tick();
            if (enable) begin
                exp = model_step();
                m_steps++;
                m_sum += exp;
                if (exp == int'(m_int) + 1) m_ones++;
                check(div_valid == 1'b1 && int'(div_out) == exp, req, div_out, exp);
            end else begin
                check(div_valid == 1'b0, "R3 no step when enable low", div_valid, 0);
            end
        end
    endtask

    task automatic check_average(input string req);
        longint err;
        err = (m_sum - m_steps * m_int) * m_den - m_steps * m_num;
        check(err <= 3 * m_den && err >= -3 * m_den, req, err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(div_valid == 1'b0, "R1 valid after reset", div_valid, 0);
        check(div_out == 9'd0, "R1 div_out after reset", div_out, 0);
        enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(div_valid == 1'b0, "R1 silent before first clear", div_valid, 0);
        end

        // R4 integer mode
        load(1'b0, 2'd3, 40, 5, 9);
        run(12, 0, "R4 integer output");

        // R7 first order carry count over one modulus window
        load(1'b1, 2'd1, 20, 7, 37);
        run(37, 0, "R6 R7 first order sequence");
        check(m_ones == 7, "R7 carries in one window", m_ones, 7);
        check(m_sum == 37 * 20 + 7, "R7 window sum", m_sum, 37 * 20 + 7);

        // R8 second order with enable gaps (R3)
        load(1'b1, 2'd2, 30, 13, 37);
        run(200, 5, "R3 R8 second order sequence");
        check_average("R10 second order average");

        // R9 third order long run
        load(1'b1, 2'd3, 50, 333, 1021);
        run(3063, 0, "R9 third order sequence");
        check_average("R10 third order average");

        // R9 order code 0 acts as first order
        load(1'b1, 2'd0, 25, 3, 11);
        run(22, 0, "R9 order code 0 as first order");
        check(m_ones == 6, "R9 order 0 carry count", m_ones, 6);

        // R6 R11 full-width modulus
        load(1'b1, 2'd3, 100, 24'hFFFFFE, 24'hFFFFFF);
        run(400, 0, "R6 full width third order");

        // R5 degenerate fractions
        load(1'b1, 2'd3, 60, 0, 100);
        run(10, 0, "R5 zero numerator");
        load(1'b1, 2'd2, 61, 100, 100);
        run(10, 0, "R5 numerator not below denominator");
        load(1'b1, 2'd1, 62, 5, 0);
        run(10, 0, "R5 zero denominator");

        // R2 input change without clear has no effect
        load(1'b1, 2'd3, 70, 17, 97);
        run(50, 0, "R2 before input change");
        numer = 24'd90; denom = 24'd101; int_div = 8'd9; order = 2'd1; frac_en = 1'b0;
        run(150, 3, "R2 after input change without clear");
        check_average("R10 average across ignored change");

        // R3 clear during enable resets the sequence
        load(1'b1, 2'd2, 33, 40, 41);
        run(82, 0, "R3 R8 restart after clear");
        check_average("R10 near-full fraction average");

        enable = 1'b0;
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule